// File: doc/BRIEF.md
# Dual-Input PWM Shoot-Through Guard

This block is the clocked logic front end of a synchronous buck half-bridge driver. A controller supplies two independent command levels, one for the high-side switch and one for the low-side switch. The block turns them into two registered gate-enable outputs and applies a small set of protection rules on the way.

The high-side path has the most protection. A command pulse, or the low gap before a pulse, that is too short is removed. If both commands stay active together for longer than a set time, the high side is vetoed until the overlap ends. A junction-temperature code with a trip threshold and a lower release threshold also vetoes the high side, with hysteresis. The low side only follows its command. Both outputs are held low until a supply-good flag is seen.

All time limits are given in nanoseconds and converted to clock cycles from the clock period parameter. At 200 MHz the defaults give an overlap limit of 6 cycles, a minimum on time of 3 cycles and a minimum off gap of 4 cycles. The trip threshold is 150 and the release threshold is 134.

Top module: `stg_guard`

## Requirements
- R1: When both commands have been high for more than OVL_CYC consecutive samples (6 by default), gate_hi is low and overlap_veto is 1. An overlap of OVL_CYC samples or fewer changes nothing.
- R2: The overlap veto does not latch. On the first sample in which either command is low, overlap_veto returns to 0, and gate_hi follows its qualified command again.
- R3: While supply_ok is 0, gate_hi and gate_lo are 0 whatever the commands are. Once supply_ok is 1, each output follows its own command.
- R4: A temp_code of 150 or more sets thermal_veto to 1 and forces gate_hi to 0. The veto stays set while temp_code is 134 or more, and it clears on the first sample below 134. A code of 149 does not set it.
- R5: Neither the thermal veto nor the overlap veto ever changes gate_lo. gate_lo equals supply_ok AND pwm_lo_cmd.
- R6: A high-side command pulse of P samples gives no gate_hi pulse when P < MIN_ON_CYC (3 by default). When P >= MIN_ON_CYC, gate_hi is high for P-MIN_ON_CYC+1 cycles and ends together with the command.
- R7: A high-side pulse whose preceding low gap is shorter than MIN_OFF_CYC samples (4 by default) is suppressed completely. The first pulse after reset counts as having a long enough gap.
- R8: Every output reflects the inputs sampled three rising edges earlier. That is two synchronizer flops, one stage of protection logic and one output register. temp_code uses the same depth.
- R9: While rst is 1, all four outputs are 0, even with both commands and supply_ok held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi_cmd | input | 1 | High-side switch command, active high |
| pwm_lo_cmd | input | 1 | Low-side switch command, active high |
| supply_ok | input | 1 | Gate-drive supply is within range |
| temp_code | input | TEMP_W | Junction temperature code in degrees, unsigned |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| overlap_veto | output | 1 | High side is vetoed because of command overlap |
| thermal_veto | output | 1 | High side is vetoed because of over-temperature |

## Verification
The properties assume that temp_code is produced in the clock domain of the block. It is only delayed to line up with the command synchronizer, and it changes seldom, so the two-flop alignment of a multi-bit code is safe. They also assume that the commands and supply_ok are single-bit levels that stay steady around the sampling edge. The stimulus changes every input on the falling clock edge. It holds each temperature value for at least several cycles, and it builds command patterns from whole-cycle run lengths, so every pulse and gap has an exact sample count.

// File: rtl/stg_pkg.sv
`timescale 1ns/1ps
package stg_pkg;

  // Convert a time in ns into a whole number of clock cycles, rounding up, with a minimum of 1.
  function automatic int ns_to_cycles(input int t_ns, input int period_ps);
    int c;
    c = (t_ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/stg_sync.sv
`timescale 1ns/1ps
module stg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/stg_pulse_filter.sv
`timescale 1ns/1ps
module stg_pulse_filter #(
  parameter int MIN_ON  = 3,
  parameter int MIN_OFF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  output logic q
);

  localparam int ON_W  = $clog2(MIN_ON + 1);
  localparam int OFF_W = $clog2(MIN_OFF + 1);
  localparam logic [ON_W-1:0]  ON_SAT  = ON_W'(MIN_ON);
  localparam logic [OFF_W-1:0] OFF_SAT = OFF_W'(MIN_OFF);

  logic [ON_W-1:0]  hi_run;   // length of the current high run, saturating
  logic [OFF_W-1:0] lo_run;   // length of the current low run, saturating
  logic             gap_ok;   // the low gap before this high run was long enough
  logic [ON_W-1:0]  hi_run_nx;
  logic             gap_ok_nx;

  always_comb begin
    hi_run_nx = (hi_run == ON_SAT) ? hi_run : hi_run + 1'b1;
    // A zero hi_run means this sample starts a new high run.
    gap_ok_nx = (hi_run == '0) ? (lo_run == OFF_SAT) : gap_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
      lo_run <= OFF_SAT;
      gap_ok <= 1'b0;
      q      <= 1'b0;
    end else if (cmd) begin
      hi_run <= hi_run_nx;
      lo_run <= '0;
      gap_ok <= gap_ok_nx;
      q      <= gap_ok_nx && (hi_run_nx == ON_SAT);
    end else begin
      hi_run <= '0;
      lo_run <= (lo_run == OFF_SAT) ? lo_run : lo_run + 1'b1;
      q      <= 1'b0;
    end
  end

endmodule

// File: rtl/stg_overlap.sv
`timescale 1ns/1ps
module stg_overlap #(
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic hi,
  input  logic lo,
  output logic veto
);

  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);

  logic [CW-1:0] run;
  logic [CW-1:0] run_nx;

  assign run_nx = (run == SAT) ? run : run + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      veto <= 1'b0;
    end else if (hi && lo) begin
      run  <= run_nx;
      veto <= (run_nx == SAT);
    end else begin
      run  <= '0;
      veto <= 1'b0;
    end
  end

endmodule

// File: rtl/stg_thermal.sv
`timescale 1ns/1ps
module stg_thermal #(
  parameter int W       = 8,
  parameter int TRIP    = 150,
  parameter int RELEASE = 134
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] temp,
  output logic         hot
);

  localparam logic [W-1:0] TRIP_C = W'(TRIP);
  localparam logic [W-1:0] REL_C  = W'(RELEASE);

  always_ff @(posedge clk) begin
    if (rst) hot <= 1'b0;
    else     hot <= hot ? (temp >= REL_C) : (temp >= TRIP_C);
  end

endmodule

// File: rtl/stg_guard.sv
`timescale 1ns/1ps
module stg_guard
  import stg_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int OVERLAP_NS    = 30,
  parameter int MIN_ON_NS     = 12,
  parameter int MIN_OFF_NS    = 17,
  parameter int SYNC_STAGES   = 2,
  parameter int TEMP_W        = 8,
  parameter int TEMP_TRIP     = 150,
  parameter int TEMP_RELEASE  = 134
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwm_hi_cmd,
  input  logic              pwm_lo_cmd,
  input  logic              supply_ok,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              gate_hi,
  output logic              gate_lo,
  output logic              overlap_veto,
  output logic              thermal_veto
);

  localparam int OVL_CYC     = ns_to_cycles(OVERLAP_NS, CLK_PERIOD_PS);
  localparam int MIN_ON_CYC  = ns_to_cycles(MIN_ON_NS, CLK_PERIOD_PS);
  localparam int MIN_OFF_CYC = ns_to_cycles(MIN_OFF_NS, CLK_PERIOD_PS);

  logic [2:0]        ctl_s;
  logic [TEMP_W-1:0] temp_s;
  logic              hi_s, lo_s, sup_s;
  logic              hi_q, veto_b, hot_b, lo_d, sup_d;

  // Stage A: synchronize the level inputs. The temperature code is delayed by the same depth.
  stg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(clk), .rst(rst), .d({supply_ok, pwm_lo_cmd, pwm_hi_cmd}), .q(ctl_s)
  );
  stg_sync #(.W(TEMP_W), .STAGES(SYNC_STAGES)) u_temp_sync (
    .clk(clk), .rst(rst), .d(temp_code), .q(temp_s)
  );

  assign hi_s  = ctl_s[0];
  assign lo_s  = ctl_s[1];
  assign sup_s = ctl_s[2];

  // Stage B: protection logic, one register deep in every path.
  stg_pulse_filter #(.MIN_ON(MIN_ON_CYC), .MIN_OFF(MIN_OFF_CYC)) u_filter (
    .clk(clk), .rst(rst), .cmd(hi_s), .q(hi_q)
  );
  stg_overlap #(.LIMIT(OVL_CYC)) u_overlap (
    .clk(clk), .rst(rst), .hi(hi_s), .lo(lo_s), .veto(veto_b)
  );
  stg_thermal #(.W(TEMP_W), .TRIP(TEMP_TRIP), .RELEASE(TEMP_RELEASE)) u_thermal (
    .clk(clk), .rst(rst), .temp(temp_s), .hot(hot_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_d  <= 1'b0;
      sup_d <= 1'b0;
    end else begin
      lo_d  <= lo_s;
      sup_d <= sup_s;
    end
  end

  // Stage C: registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi      <= 1'b0;
      gate_lo      <= 1'b0;
      overlap_veto <= 1'b0;
      thermal_veto <= 1'b0;
    end else begin
      gate_hi      <= sup_d && hi_q && !veto_b && !hot_b;
      gate_lo      <= sup_d && lo_d;
      overlap_veto <= veto_b;
      thermal_veto <= hot_b;
    end
  end

endmodule

// File: rtl/stg_guard_chk.sv
`timescale 1ns/1ps
module stg_guard_chk #(
  parameter int OVL_CYC    = 6,
  parameter int MIN_ON_CYC = 3
) (
  input logic clk,
  input logic rst,
  input logic hi_s,
  input logic sup_d,
  input logic hot_b,
  input logic gate_hi,
  input logic gate_lo,
  input logic thermal_veto
);

  int both_run;   // previous consecutive cycles with both gates enabled
  int hi_run;     // consecutive synchronized high-side command samples
  int hi_run_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      both_run <= 0;
      hi_run   <= 0;
      hi_run_d <= 0;
    end else begin
      both_run <= (gate_hi && gate_lo) ? ((both_run > OVL_CYC) ? both_run : both_run + 1) : 0;
      hi_run   <= hi_s ? ((hi_run < MIN_ON_CYC) ? hi_run + 1 : hi_run) : 0;
      hi_run_d <= hi_run;
    end
  end

  assert_overlap_window_R1: assert property (@(posedge clk) disable iff (rst)
    (gate_hi && gate_lo) |-> (both_run < OVL_CYC));

  assert_startup_low_R3: assert property (@(posedge clk) disable iff (rst)
    !sup_d |=> (!gate_hi && !gate_lo));

  assert_thermal_veto_R4: assert property (@(posedge clk) disable iff (rst)
    hot_b |=> (!gate_hi && thermal_veto));

  assert_min_on_R6: assert property (@(posedge clk) disable iff (rst)
    gate_hi |-> (hi_run_d >= MIN_ON_CYC));

endmodule

bind stg_guard stg_guard_chk #(.OVL_CYC(OVL_CYC), .MIN_ON_CYC(MIN_ON_CYC)) u_chk (
  .clk(clk), .rst(rst), .hi_s(hi_s), .sup_d(sup_d), .hot_b(hot_b),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .thermal_veto(thermal_veto)
);

// File: tb/stg_guard_bench.sv
`timescale 1ns/1ps
module stg_guard_bench;

  localparam int OVL_C     = (30 + 4) / 5;   // 30 ns at 5 ns, rounded up
  localparam int MIN_ON_C  = (12 + 4) / 5;
  localparam int MIN_OFF_C = (17 + 4) / 5;
  localparam int TRIP_C    = 150;
  localparam int REL_C     = 134;
  localparam int LAT       = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_hi_cmd = 1'b0, pwm_lo_cmd = 1'b0, supply_ok = 1'b0;
  logic [7:0] temp_code = 8'd25;
  logic       gate_hi, gate_lo, overlap_veto, thermal_veto;

  int checks = 0;
  int failures = 0;
  bit sb_on = 1'b0;
  bit done = 1'b0;

  bit [3:0] exp_q[$];
  string    tag_q[$];

  // Model state, built from the requirements.
  int  m_hrun = 0, m_lrun = 1000, m_gap = 0, m_orun = 0;
  bit  m_hot = 1'b0;

  always #2.5 clk = ~clk;

  stg_guard u_stg_guard (
    .clk(clk), .rst(rst), .pwm_hi_cmd(pwm_hi_cmd), .pwm_lo_cmd(pwm_lo_cmd),
    .supply_ok(supply_ok), .temp_code(temp_code), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .overlap_veto(overlap_veto), .thermal_veto(thermal_veto)
  );

  // Driver: apply one sample and queue the outputs expected LAT edges later.
  task automatic push_sample(input bit hi, input bit lo, input bit sup, input int temp, input string tag);
    bit q_hi, ov;
    pwm_hi_cmd = hi;
    pwm_lo_cmd = lo;
    supply_ok  = sup;
    temp_code  = 8'(temp);
    if (hi) begin
      if (m_hrun == 0) m_gap = m_lrun;
      m_hrun++;
      m_lrun = 0;
    end else begin
      m_hrun = 0;
      m_lrun++;
    end
    q_hi   = hi && (m_hrun >= MIN_ON_C) && (m_gap >= MIN_OFF_C);
    m_orun = (hi && lo) ? m_orun + 1 : 0;
    ov     = (m_orun > OVL_C);
    m_hot  = m_hot ? (temp >= REL_C) : (temp >= TRIP_C);
    exp_q.push_back({sup && q_hi && !ov && !m_hot, sup && lo, ov, m_hot});
    tag_q.push_back(tag);
  endtask

  task automatic step(input bit hi, input bit lo, input bit sup, input int temp, input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push_sample(hi, lo, sup, temp, tag);
    end
  endtask

  // Monitor: compare against the scoreboard just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (sb_on && !done && exp_q.size() > LAT) begin
      bit [3:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {gate_hi, gate_lo, overlap_veto, thermal_veto};
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s {gate_hi,gate_lo,ovl,therm} actual=%b expected=%b at %0t", t, a, e, $time);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset holds every output low while the inputs are active
    pwm_hi_cmd = 1'b1; pwm_lo_cmd = 1'b1; supply_ok = 1'b1; temp_code = 8'd200;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        checks++;
        if ({gate_hi, gate_lo, overlap_veto, thermal_veto} !== 4'b0000) begin
          failures++;
          $display("FAIL R9 reset outputs actual=%b expected=0000",
                   {gate_hi, gate_lo, overlap_veto, thermal_veto});
        end
      end
    end
    pwm_hi_cmd = 1'b0; pwm_lo_cmd = 1'b0; supply_ok = 1'b0; temp_code = 8'd25;
    @(negedge clk);
    rst = 1'b0;
    sb_on = 1'b1;
    push_sample(0, 0, 0, 25, "R9");

    // R3: no supply means no gates; once supply is good, each gate follows its command
    step(1, 0, 0, 25, "R3", 8);
    step(0, 1, 0, 25, "R3", 8);
    step(1, 1, 0, 25, "R3", 4);
    step(0, 0, 0, 25, "R3", 5);
    step(0, 0, 1, 25, "R3", 6);
    step(1, 0, 1, 25, "R3", 8);
    step(0, 0, 1, 25, "R3", 5);
    step(0, 1, 1, 25, "R3", 6);

    // R8: a one-cycle low-side pulse passes through after three edges
    step(0, 0, 1, 25, "R8", 5);
    step(0, 1, 1, 25, "R8", 1);
    step(0, 0, 1, 25, "R8", 5);
    step(0, 1, 1, 25, "R8", 2);
    step(0, 0, 1, 25, "R8", 5);

    // R6: high-side pulses of length 1 to 6
    for (int len = 1; len <= 6; len++) begin
      step(0, 0, 1, 25, "R6", 6);
      step(1, 0, 1, 25, "R6", len);
    end
    step(0, 0, 1, 25, "R6", 6);

    // R7: a short gap suppresses the next pulse, a gap of MIN_OFF_C does not
    step(1, 0, 1, 25, "R7", 5);
    step(0, 0, 1, 25, "R7", MIN_OFF_C - 1);
    step(1, 0, 1, 25, "R7", 5);
    step(0, 0, 1, 25, "R7", MIN_OFF_C);
    step(1, 0, 1, 25, "R7", 5);
    step(0, 0, 1, 25, "R7", 1);
    step(1, 0, 1, 25, "R7", 5);
    step(0, 0, 1, 25, "R7", 6);

    // R1: overlap of exactly the limit is tolerated, a longer one vetoes the high side
    step(0, 1, 1, 25, "R1", 2);
    step(1, 1, 1, 25, "R1", OVL_C);
    step(0, 1, 1, 25, "R1", 5);
    step(1, 1, 1, 25, "R1", OVL_C + 6);
    step(0, 0, 1, 25, "R1", 6);

    // R2: dropping either command ends the veto with no latch
    step(0, 1, 1, 25, "R2", 2);
    step(1, 1, 1, 25, "R2", 10);
    step(1, 0, 1, 25, "R2", 6);
    step(1, 1, 1, 25, "R2", 9);
    step(1, 0, 1, 25, "R2", 3);
    step(0, 0, 1, 25, "R2", 6);
    step(1, 1, 1, 25, "R2", 10);
    step(0, 1, 1, 25, "R2", 5);
    step(1, 1, 1, 25, "R2", 4);
    step(0, 0, 1, 25, "R2", 6);

    // R4: trip at 150, hold down to 134, release below 134
    step(1, 0, 1, 149, "R4", 8);
    step(1, 0, 1, 150, "R4", 6);
    step(1, 0, 1, 140, "R4", 6);
    step(1, 0, 1, 134, "R4", 6);
    step(1, 0, 1, 133, "R4", 6);
    step(1, 0, 1, 145, "R4", 6);
    step(0, 0, 1, 25, "R4", 6);

    // R5: the low side is unaffected by either veto
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 1, 160, "R5", 3);
      step(0, 0, 1, 160, "R5", 2);
    end
    step(1, 1, 1, 160, "R5", 12);
    step(0, 0, 1, 25, "R5", 4);
    step(1, 1, 1, 25, "R5", 14);
    step(0, 0, 1, 25, "R5", 6);

    // Mixed run lengths, temperatures and supply drops
    for (int k = 0; k < 400; k++) begin
      int t;
      t = 120 + ((k / 20) * 7) % 45;
      step(1'($urandom % 2), 1'($urandom % 2), (k % 97) != 50, t, "R8", 1 + ($urandom % 9));
    end

    step(0, 0, 1, 25, "R8", LAT + 2);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule